// File: doc/BRIEF.md
# Latchup Protection Power-Cycle Sequencer

This controller sits beside the supply switch of a protected device. It watches a digital overcurrent flag from the supply path and a self-test request. When either trigger appears it raises a status flag and opens a qualification window. The supply is cut only if the overcurrent stays present for the whole window, or if the window was opened by a qualified self-test request. If the overcurrent clears early, the window closes and the supply is never removed.

After a supply cut, the controller reports recovery in stages. First the supply is off. Then the supply returns, but the device outputs are still unusable. After that the outputs are usable at reduced accuracy. Finally full accuracy is declared. Every interval is a count of clock cycles set by a parameter, so one design serves any clock rate. A test bench can also shrink the intervals.

Top module: `lup_seq`

## Requirements
- R1: A synchronous reset puts the block in idle with `pwr_en`=1, `prot_status`=0, `outs_valid`=1 and `full_acc`=1.
- R2: Both trigger inputs pass through a two-flop synchronizer. In idle, an `oc_det` level that is high before clock edge 1 makes `prot_status` high after edge 3. That opens a qualification window of DECIDE_CYC cycles.
- R3: The supply is not removed if the synchronized overcurrent is low in any cycle from the one that opened the window to the window's last cycle. In that case `prot_status` falls when the window ends, and `outs_valid` and `full_acc` do not move. With the defaults of the bench, a pulse of DECIDE_CYC input cycles or fewer gives DECIDE_CYC status-high cycles and no cut.
- R4: The supply is removed if the overcurrent persists through the window (DECIDE_CYC+1 input cycles or more). In that case `pwr_en` is low for exactly OFF_CYC cycles, and `prot_status` stays high for that whole interval.
- R5: After the supply returns, `prot_status` stays high for exactly RELEASE_CYC more cycles and then falls.
- R6: `outs_valid` goes low in the cycle the supply is cut. It returns high exactly INVALID_CYC cycles after `prot_status` falls.
- R7: `full_acc` goes low in the cycle the supply is cut. It returns high exactly SETTLE_CYC cycles after `outs_valid` returns, unless a new event intervenes.
- R8: A `selftest` level held high for more than TEST_CYC consecutive input cycles forces a full supply cycle, even with no overcurrent. A level held for TEST_CYC cycles or fewer has no effect.
- R9: Triggers that arrive during the window, the supply-off interval, the release interval or the invalid-output interval are ignored.
- R10: A trigger during the reduced-accuracy phase opens a new window while `full_acc` stays low. If that window is cancelled, the reduced-accuracy phase restarts its full SETTLE_CYC count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_det | input | 1 | Overcurrent flag from the supply path, asynchronous |
| selftest | input | 1 | Self-test request level, asynchronous, low in normal use |
| pwr_en | output | 1 | Supply enable for the protected device |
| prot_status | output | 1 | High during the window, the supply-off interval and the release interval |
| outs_valid | output | 1 | Device outputs usable |
| full_acc | output | 1 | Device at full accuracy |

## Verification
The assertions take for granted that every supply cut is preceded by a status-high cycle. They also assume that `outs_valid` only drops together with `pwr_en`, and that `full_acc` implies `outs_valid`. Those relations hold only if the triggers are clean levels that the synchronizer can sample. The stimulus therefore changes `oc_det` and `selftest` only on falling clock edges and holds each level for whole cycles. It keeps every pulse short enough to end before the reduced-accuracy phase begins, except where that phase is the target. As a result, every expected count follows from the parameter values alone.

// File: rtl/lup_pkg.sv
package lup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_OFF,
        ST_RELEASE,
        ST_INVALID,
        ST_DEGRADED
    } lup_state_e;

    typedef struct packed {
        logic pwr_en;
        logic status;
        logic valid;
    } lup_flags_t;

    function automatic lup_flags_t flags_of(lup_state_e s);
        lup_flags_t f;
        f.pwr_en = (s != ST_OFF);
        f.status = (s == ST_DECIDE) || (s == ST_OFF) || (s == ST_RELEASE);
        f.valid  = !((s == ST_OFF) || (s == ST_RELEASE) || (s == ST_INVALID));
        return f;
    endfunction

    function automatic int max5(int a, int b, int c, int d, int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/lup_sync.sv
module lup_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/lup_pulse_qual.sv
module lup_pulse_qual #(
    parameter int MIN_CYC = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic hit
);
    localparam int CW = $clog2(MIN_CYC + 2);
    localparam logic [CW-1:0] SAT = CW'(MIN_CYC + 1);
    localparam logic [CW-1:0] THR = CW'(MIN_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !lvl) cnt <= '0;
        else if (cnt != SAT) cnt <= cnt + 1'b1;
    end

    // one-cycle strobe on the first cycle the level exceeds MIN_CYC
    assign hit = lvl && (cnt == THR);
endmodule

// File: rtl/lup_timer.sv
module lup_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (load) cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/lup_seq.sv
module lup_seq
    import lup_pkg::*;
#(
    parameter int DECIDE_CYC  = 1000,
    parameter int OFF_CYC     = 5000,
    parameter int RELEASE_CYC = 50,
    parameter int INVALID_CYC = 2500,
    parameter int SETTLE_CYC  = 500000,
    parameter int TEST_CYC    = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_det,
    input  logic selftest,
    output logic pwr_en,
    output logic prot_status,
    output logic outs_valid,
    output logic full_acc
);
    localparam int MAXC = max5(DECIDE_CYC, OFF_CYC, RELEASE_CYC, INVALID_CYC, SETTLE_CYC);
    localparam int TW   = $clog2(MAXC + 1);

    logic [1:0]    sync_q;
    logic          oc_s, tst_s, t_hit, trig;
    logic          tmr_done, ld;
    logic [TW-1:0] ld_val;
    lup_state_e    state, nxt;
    logic          held_q, forced_q, acc_q;
    lup_flags_t    fl;

    lup_sync #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({selftest, oc_det}),
        .q   (sync_q)
    );
    assign oc_s  = sync_q[0];
    assign tst_s = sync_q[1];

    lup_pulse_qual #(.MIN_CYC(TEST_CYC)) u_qual (
        .clk (clk),
        .rst (rst),
        .lvl (tst_s),
        .hit (t_hit)
    );

    lup_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .done     (tmr_done)
    );

    assign trig = oc_s || t_hit;

    always_comb begin
        nxt    = state;
        ld     = 1'b0;
        ld_val = '0;
        unique case (state)
            ST_IDLE: if (trig) begin
                nxt = ST_DECIDE; ld = 1'b1; ld_val = TW'(DECIDE_CYC - 1);
            end
            ST_DECIDE: if (tmr_done) begin
                if (forced_q || (held_q && oc_s)) begin
                    nxt = ST_OFF; ld = 1'b1; ld_val = TW'(OFF_CYC - 1);
                end else if (acc_q) begin
                    nxt = ST_IDLE;
                end else begin
                    nxt = ST_DEGRADED; ld = 1'b1; ld_val = TW'(SETTLE_CYC - 1);
                end
            end
            ST_OFF: if (tmr_done) begin
                nxt = ST_RELEASE; ld = 1'b1; ld_val = TW'(RELEASE_CYC - 1);
            end
            ST_RELEASE: if (tmr_done) begin
                nxt = ST_INVALID; ld = 1'b1; ld_val = TW'(INVALID_CYC - 1);
            end
            ST_INVALID: if (tmr_done) begin
                nxt = ST_DEGRADED; ld = 1'b1; ld_val = TW'(SETTLE_CYC - 1);
            end
            ST_DEGRADED: begin
                if (trig) begin
                    nxt = ST_DECIDE; ld = 1'b1; ld_val = TW'(DECIDE_CYC - 1);
                end else if (tmr_done) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            held_q   <= 1'b0;
            forced_q <= 1'b0;
            acc_q    <= 1'b1;
        end else begin
            state <= nxt;
            if (state != ST_DECIDE && nxt == ST_DECIDE) begin
                held_q   <= 1'b1;
                forced_q <= t_hit;
            end else if (state == ST_DECIDE) begin
                held_q <= held_q && oc_s;
            end
            if (state != ST_OFF && nxt == ST_OFF) acc_q <= 1'b0;
            else if (state == ST_DEGRADED && nxt == ST_IDLE) acc_q <= 1'b1;
        end
    end

    assign fl          = flags_of(state);
    assign pwr_en      = fl.pwr_en;
    assign prot_status = fl.status;
    assign outs_valid  = fl.valid;
    assign full_acc    = acc_q;
endmodule

// File: rtl/lup_seq_chk.sv
module lup_seq_chk (
    input logic clk,
    input logic rst,
    input logic pwr_en,
    input logic prot_status,
    input logic outs_valid,
    input logic full_acc
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pwr_en && !prot_status && outs_valid && full_acc));

    p_cut_after_window_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_en) |-> $past(prot_status));

    p_off_flagged_r4: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |-> (prot_status && !outs_valid));

    p_restore_status_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_en) |-> prot_status);

    p_valid_drop_cut_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(outs_valid) |-> !pwr_en);

    p_full_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
        full_acc |-> outs_valid);
endmodule

bind lup_seq lup_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_en      (pwr_en),
    .prot_status (prot_status),
    .outs_valid  (outs_valid),
    .full_acc    (full_acc)
);

// File: tb/sim_lup_seq.sv
module sim_lup_seq;
    localparam int DEC = 8, OFF = 12, REL = 3, INV = 6, SET = 20, TST = 5;
    localparam int NV = 10;
    // columns: oc pulse, selftest pulse, expect cut, expect status-high cycles
    localparam int VEC [NV][4] = '{
        '{0, 0, 0, 0},  '{1, 0, 0, 8},  '{8, 0, 0, 8},  '{9, 0, 1, 23},
        '{14, 0, 1, 23}, '{0, 5, 0, 0},  '{0, 6, 1, 23}, '{0, 10, 1, 23},
        '{3, 6, 0, 8},  '{8, 3, 0, 8}
    };

    logic clk = 1'b0, rst = 1'b1, oc_det = 1'b0, selftest = 1'b0;
    logic pwr_en, prot_status, outs_valid, full_acc;
    int nchk = 0, nfail = 0;
    bit fin = 1'b0;
    int cyc = 0, off_c = 0, st_c = 0, inv_c = 0, acc_c = 0, full_rises = 0;
    int t_st_rise = 0, t_pwr_fall = 0, t_pwr_rise = 0, t_st_fall = 0, t_val_rise = 0, t_full_rise = 0;
    logic p_pwr = 1'b1, p_st = 1'b0, p_val = 1'b1, p_full = 1'b1;

    always #5 clk = ~clk;

    lup_seq #(.DECIDE_CYC(DEC), .OFF_CYC(OFF), .RELEASE_CYC(REL),
              .INVALID_CYC(INV), .SETTLE_CYC(SET), .TEST_CYC(TST)) u0 (
        .clk(clk), .rst(rst), .oc_det(oc_det), .selftest(selftest),
        .pwr_en(pwr_en), .prot_status(prot_status),
        .outs_valid(outs_valid), .full_acc(full_acc)
    );

    always @(posedge clk) begin
        #2;
        cyc++;
        if (!pwr_en) off_c++;
        if (prot_status) st_c++;
        if (!outs_valid) inv_c++;
        if (!full_acc) acc_c++;
        if (prot_status && !p_st) t_st_rise = cyc;
        if (!prot_status && p_st) t_st_fall = cyc;
        if (!pwr_en && p_pwr) t_pwr_fall = cyc;
        if (pwr_en && !p_pwr) t_pwr_rise = cyc;
        if (outs_valid && !p_val) t_val_rise = cyc;
        if (full_acc && !p_full) begin t_full_rise = cyc; full_rises++; end
        p_pwr = pwr_en; p_st = prot_status; p_val = outs_valid; p_full = full_acc;
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int oc_len, input int t_len);
        int m;
        m = (oc_len > t_len) ? oc_len : t_len;
        for (int i = 0; i < m; i++) begin
            oc_det = (i < oc_len);
            selftest = (i < t_len);
            @(negedge clk);
        end
        oc_det = 1'b0;
        selftest = 1'b0;
    endtask

    initial begin
        int b_off, b_st, b_inv, b_acc, b_fr, t0, m;
        string tag;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        // R1 reset state
        chk("R1 pwr_en", pwr_en, 1);
        chk("R1 status", prot_status, 0);
        chk("R1 valid", outs_valid, 1);
        chk("R1 full", full_acc, 1);

        for (int v = 0; v < NV; v++) begin
            tag = (VEC[v][1] > 0) ? ((VEC[v][0] > 0) ? "R9" : "R8") : ((VEC[v][2] != 0) ? "R4" : "R3");
            b_off = off_c; b_st = st_c; b_inv = inv_c; b_acc = acc_c;
            pulse(VEC[v][0], VEC[v][1]);
            m = (VEC[v][0] > VEC[v][1]) ? VEC[v][0] : VEC[v][1];
            wait_n(90 - m);
            chk({tag, " off cycles"}, off_c - b_off, VEC[v][2] * OFF);
            chk({tag, " status cycles"}, st_c - b_st, VEC[v][3]);
            chk({tag, " invalid cycles"}, inv_c - b_inv, VEC[v][2] * (OFF + REL + INV));
            chk({tag, " degraded cycles"}, acc_c - b_acc, VEC[v][2] * (OFF + REL + INV + SET));
        end

        // R2 R4 R5 R6 R7 stage timing of one full cycle
        t0 = cyc;
        pulse(12, 0);
        wait_n(80);
        chk("R2 status rise latency", t_st_rise - t0, 3);
        chk("R4 window length", t_pwr_fall - t_st_rise, DEC);
        chk("R4 off length", t_pwr_rise - t_pwr_fall, OFF);
        chk("R5 release length", t_st_fall - t_pwr_rise, REL);
        chk("R6 invalid length", t_val_rise - t_st_fall, INV);
        chk("R7 settle length", t_full_rise - t_val_rise, SET);

        // R9 selftest during off and overcurrent during invalid are ignored
        b_off = off_c; b_st = st_c;
        pulse(12, 0);
        wait_n(2);
        pulse(0, 10);
        pulse(5, 0);
        wait_n(90 - 29);
        chk("R9 off cycles", off_c - b_off, OFF);
        chk("R9 status cycles", st_c - b_st, DEC + OFF + REL);

        // R10 retrigger in degraded phase causes a second cut without full_acc rising
        b_off = off_c; b_fr = full_rises;
        pulse(12, 0);
        wait_n(35 - 12);
        pulse(12, 0);
        wait_n(120);
        chk("R10 second cut off cycles", off_c - b_off, 2 * OFF);
        chk("R10 full rises", full_rises - b_fr, 1);

        // R10 cancelled window in degraded phase restarts settle count
        b_off = off_c; b_st = st_c; b_acc = acc_c; b_fr = full_rises;
        pulse(12, 0);
        wait_n(35 - 12);
        pulse(3, 0);
        wait_n(80);
        chk("R10 cancel off cycles", off_c - b_off, OFF);
        chk("R10 cancel status cycles", st_c - b_st, DEC + OFF + REL + DEC);
        // degraded phase ran 6 cycles before the new window, then restarts fully
        chk("R10 cancel degraded cycles", acc_c - b_acc, OFF + REL + INV + 6 + DEC + SET);
        chk("R10 cancel full rises", full_rises - b_fr, 1);

        // R1 reset in the middle of the off interval
        pulse(12, 0);
        wait_n(2);
        chk("R1 pre-reset cut", pwr_en, 0);
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
        wait_n(1);
        chk("R1 mid reset pwr_en", pwr_en, 1);
        chk("R1 mid reset status", prot_status, 0);
        chk("R1 mid reset full", full_acc, 1);

        fin = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!fin) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule